// File: doc/BRIEF.md
# Two-Beat Burst SRAM Emulator with Separate Read and Write Ports

This block is a synthesizable stand-in for a burst-of-two static memory that has independent read and write data buses. The two half-cycles of each main cycle run as two ticks of a single double-rate clock. A free-running phase bit marks which tick is the main-cycle rising edge, and the block shows it on `k_rise`. At that edge the block samples the active-low read select, the active-low write select and one shared word address. The read and write paths run side by side, and both may start at the same edge.

A write takes its first data word at the main edge and its second at the mid-cycle tick that follows. Each beat carries its own active-low lane enables. A read returns two words on `q` while `q_oe` is high. The first word arrives three ticks after the start edge and the second comes one tick later. Both bursts cover the latched word and then its partner in the same aligned pair. The storage holds `2**ADDR_W` words, stored as pairs so that one read fetches a whole burst at once.

Top module: `qdr2_sram_emu`

## Requirements
- R1: While reset is applied, and once it is released, `q_oe` is low and `k_rise` is high. After release `k_rise` alternates on every clock tick.
- R2: A low `wr_n` at a main edge (a tick where `k_rise` was high beforehand) stores the `wdata` present at that tick into the word at the latched address.
- R3: At the mid-cycle tick that follows, the `wdata` present at that tick is stored into the partner word, whose address is the latched address with bit 0 inverted.
- R4: A low `rd_n` at a main edge drives `q_oe` high with the latched word on `q` after exactly three ticks, and for no tick before that.
- R5: One tick after the first word, `q` carries the partner word (address bit 0 inverted, so the burst wraps inside the aligned pair) and `q_oe` stays high. `q_oe` then falls unless another read follows.
- R6: Lane l covers `wdata` bits [9l+8 : 9l]. When `bw_n[l]` is 0 during a write beat, that lane is stored. When it is 1, that lane of the word keeps its old value.
- R7: `bw_n` is sampled separately at each of the two write beats, and the two samples may differ within one burst.
- R8: When both selects are high at a main edge, nothing is stored, whatever `wdata` and `bw_n` hold, and that edge never causes `q_oe` to rise.
- R9: When a read and a write start at the same main edge on the same address, the read returns the contents from before that write.
- R10: Reads started at consecutive main edges keep `q_oe` high with no gap, and each burst delivers its words in order.
- R11: Selects and address that are low or changed at a mid-cycle tick are ignored. No write and no read starts at that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; each rising edge is one beat tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_n | input | 1 | Active-low read start, sampled at main edges |
| wr_n | input | 1 | Active-low write start, sampled at main edges |
| addr | input | ADDR_W | Word address, sampled at main edges |
| bw_n | input | LANES | Active-low lane write enables, sampled at each write beat |
| wdata | input | LANES*LANE_W | Write data, one word per beat |
| q | output | LANES*LANE_W | Read data |
| q_oe | output | 1 | Read data valid; low stands for a high-impedance bus |
| k_rise | output | 1 | High when the next tick is a main-cycle rising edge |

## Verification
Both write beats land in the tick in which they are sampled, so the bench updates its reference memory as it drives each beat. A read's first word is registered at the third tick after its start edge, and its second word one tick later. The bench holds a 16-slot ring of expected output values keyed by its falling-edge count. Each read fills slots n+4 and n+5, where n is the count at which the read was driven. At every falling edge the bench compares `q_oe` and `q` against the slot for that edge, and any slot that holds no expectation must show `q_oe` low. Because of this, an early output, a late output or an extra beat is caught at the exact tick where it occurs.

// File: rtl/qdr2_pkg.sv
package qdr2_pkg;
  localparam int unsigned DEF_ADDR_W = 9;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_LANE_W = 9;

  typedef enum logic {
    BEAT_K  = 1'b0,
    BEAT_KN = 1'b1
  } beat_e;
endpackage

// File: rtl/qdr2_rst_sync.sv
module qdr2_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_s_n <= meta_q;
    end
  end
endmodule

// File: rtl/qdr2_mem.sv
module qdr2_mem #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANES * LANE_W,
  localparam int unsigned PAIR_W = ADDR_W - 1,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                we,
  input  logic [PAIR_W-1:0]   wpair,
  input  logic                wsel,
  input  logic [LANES-1:0]    lane_en,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [PAIR_W-1:0]   rpair,
  output logic [2*WORD_W-1:0] rpair_data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lane_en[l]) begin
        bank[{wpair, wsel}] <= wdata[l*LANE_W +: LANE_W];
      end
    end

    always_comb begin
      rpair_data[l*LANE_W +: LANE_W]          = bank[{rpair, 1'b0}];
      rpair_data[WORD_W + l*LANE_W +: LANE_W] = bank[{rpair, 1'b1}];
    end
  end
endmodule

// File: rtl/qdr2_wr_ctl.sv
module qdr2_wr_ctl #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANES  = 2,
  localparam int unsigned PAIR_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              k_beat,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  output logic              mem_we,
  output logic [PAIR_W-1:0] mem_pair,
  output logic              mem_sel,
  output logic [LANES-1:0]  mem_lane_en
);
  logic              pend_q, pend_d;
  logic [PAIR_W-1:0] pair_q;
  logic              sel_q;
  logic              lat_en;

  always_comb begin
    lat_en      = k_beat && !wr_n;
    pend_d      = pend_q;
    mem_we      = 1'b0;
    mem_pair    = pair_q;
    mem_sel     = ~sel_q;
    mem_lane_en = ~bw_n;
    if (k_beat) begin
      pend_d   = !wr_n;
      mem_we   = !wr_n;
      mem_pair = addr[ADDR_W-1:1];
      mem_sel  = addr[0];
    end else begin
      pend_d = 1'b0;
      mem_we = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pair_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (lat_en) begin
        pair_q <= addr[ADDR_W-1:1];
        sel_q  <= addr[0];
      end
    end
  end
endmodule

// File: rtl/qdr2_rd_pipe.sv
module qdr2_rd_pipe #(
  parameter int unsigned WORD_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                k_beat,
  input  logic                rd_n,
  input  logic                first_odd,
  input  logic [2*WORD_W-1:0] pair_data,
  output logic [WORD_W-1:0]   q,
  output logic                q_oe
);
  logic              v1_q, v2_q;
  logic [WORD_W-1:0] a1_q, b1_q, a2_q, b2_q;
  logic [WORD_W-1:0] a1_d, b1_d, q_d;
  logic              ld1, ld2, ldq;

  always_comb begin
    a1_d = first_odd ? pair_data[WORD_W +: WORD_W] : pair_data[0 +: WORD_W];
    b1_d = first_odd ? pair_data[0 +: WORD_W] : pair_data[WORD_W +: WORD_W];
    ld1  = k_beat && !rd_n;
    ld2  = k_beat && v1_q;
    ldq  = v2_q;
    q_d  = k_beat ? b2_q : a2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      a1_q <= '0;
      b1_q <= '0;
      a2_q <= '0;
      b2_q <= '0;
      q    <= '0;
      q_oe <= 1'b0;
    end else begin
      q_oe <= v2_q;
      if (ldq) q <= q_d;
      if (k_beat) begin
        v1_q <= !rd_n;
        v2_q <= v1_q;
      end
      if (ld1) begin
        a1_q <= a1_d;
        b1_q <= b1_d;
      end
      if (ld2) begin
        a2_q <= a1_q;
        b2_q <= b1_q;
      end
    end
  end
endmodule

// File: rtl/qdr2_sram_emu.sv
module qdr2_sram_emu
  import qdr2_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W,
  localparam int unsigned WORD_W = LANES * LANE_W,
  localparam int unsigned PAIR_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q,
  output logic              q_oe,
  output logic              k_rise
);
  logic                rst_s_n;
  beat_e               beat_q, beat_d;
  logic                k_beat;
  logic                mem_we, mem_sel;
  logic [PAIR_W-1:0]   mem_pair;
  logic [LANES-1:0]    mem_lane_en;
  logic [2*WORD_W-1:0] rd_pair;

  qdr2_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_s_n(rst_s_n)
  );

  always_comb begin
    k_beat = (beat_q == BEAT_K);
    beat_d = k_beat ? BEAT_KN : BEAT_K;
    k_rise = k_beat;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) beat_q <= BEAT_K;
    else          beat_q <= beat_d;
  end

  qdr2_wr_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wr (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .k_beat     (k_beat),
    .wr_n       (wr_n),
    .addr       (addr),
    .bw_n       (bw_n),
    .mem_we     (mem_we),
    .mem_pair   (mem_pair),
    .mem_sel    (mem_sel),
    .mem_lane_en(mem_lane_en)
  );

  qdr2_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk       (clk),
    .we        (mem_we),
    .wpair     (mem_pair),
    .wsel      (mem_sel),
    .lane_en   (mem_lane_en),
    .wdata     (wdata),
    .rpair     (addr[ADDR_W-1:1]),
    .rpair_data(rd_pair)
  );

  qdr2_rd_pipe #(.WORD_W(WORD_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .k_beat   (k_beat),
    .rd_n     (rd_n),
    .first_odd(addr[0]),
    .pair_data(rd_pair),
    .q        (q),
    .q_oe     (q_oe)
  );
endmodule

// File: rtl/qdr2_sram_emu_chk.sv
module qdr2_sram_emu_chk (
  input logic clk,
  input logic rs_n,
  input logic rd_n,
  input logic k_rise,
  input logic q_oe
);
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rs_n)
    k_rise |=> !k_rise); // R1

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rs_n)
    (k_rise && !rd_n) |-> ##4 q_oe); // R4

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rs_n)
    (k_rise && rd_n) |-> ##4 !q_oe); // R8

  AST_FIRST_ON_MAIN: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(q_oe) |-> k_rise); // R4

  AST_TWO_BEATS: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(q_oe) |=> q_oe); // R5
endmodule

bind qdr2_sram_emu qdr2_sram_emu_chk chk_i (
  .clk   (clk),
  .rs_n  (rst_s_n),
  .rd_n  (rd_n),
  .k_rise(k_rise),
  .q_oe  (q_oe)
);

// File: tb/qdr2_sram_emu_tb_top.sv
module qdr2_sram_emu_tb_top;
  logic        clk;
  logic        rst_n;
  logic        rd_n;
  logic        wr_n;
  logic [8:0]  addr;
  logic [1:0]  bw_n;
  logic [17:0] wdata;
  logic [17:0] q;
  logic        q_oe;
  logic        k_rise;

  int          n_chk;
  int          n_err;
  int          cyc;
  bit          done;
  logic [17:0] ref_mem [512];
  bit          exp_v [16];
  logic [17:0] exp_d [16];
  string       exp_t [16];

  qdr2_sram_emu dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .addr  (addr),
    .bw_n  (bw_n),
    .wdata (wdata),
    .q     (q),
    .q_oe  (q_oe),
    .k_rise(k_rise)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [17:0] merge(input logic [17:0] old, input logic [17:0] d,
                                        input logic [1:0] m);
    logic [17:0] r;
    r = old;
    if (!m[0]) r[8:0]  = d[8:0];
    if (!m[1]) r[17:9] = d[17:9];
    return r;
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at step %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    int s;
    @(negedge clk);
    cyc++;
    s = cyc % 16;
    check(exp_v[s] ? exp_t[s] : "R8 oe idle", {17'd0, q_oe}, {17'd0, exp_v[s]});
    if (exp_v[s]) check(exp_t[s], q, exp_d[s]);
    exp_v[s] = 1'b0;
  endtask

  // Caller stands at a falling edge with k_rise high.
  task automatic op(input bit rd, input bit wr, input logic [8:0] a,
                    input logic [17:0] d0, input logic [1:0] m0,
                    input logic [17:0] d1, input logic [1:0] m1,
                    input bit mid_noise, input string rtag);
    if (rd) begin
      exp_v[(cyc+4)%16] = 1'b1;
      exp_d[(cyc+4)%16] = ref_mem[a];
      exp_t[(cyc+4)%16] = {rtag, " first word"};
      exp_v[(cyc+5)%16] = 1'b1;
      exp_d[(cyc+5)%16] = ref_mem[a ^ 9'd1];
      exp_t[(cyc+5)%16] = {rtag, " second word"};
    end
    if (wr) ref_mem[a] = merge(ref_mem[a], d0, m0);
    rd_n = !rd; wr_n = !wr; addr = a; wdata = d0; bw_n = m0;
    step();
    wdata = d1; bw_n = m1;
    if (mid_noise) begin
      rd_n = 1'b0; wr_n = 1'b0; addr = a ^ 9'd1;
    end else begin
      rd_n = 1'b1; wr_n = 1'b1;
    end
    if (wr) ref_mem[a ^ 9'd1] = merge(ref_mem[a ^ 9'd1], d1, m1);
    step();
    rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 oe in reset", {17'd0, q_oe}, 18'd0);
    check("R1 k_rise in reset", {17'd0, k_rise}, 18'd1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    while (k_rise !== 1'b1) step();
    check("R1 k_rise after release", {17'd0, k_rise}, 18'd1);
    step();
    check("R1 k_rise toggles", {17'd0, k_rise}, 18'd0);
    step();
  endtask

  task automatic t_fill();
    for (int p = 0; p < 8; p++) begin
      logic [8:0] a;
      a = 9'(2 * p);
      op(1'b0, 1'b1, a, 18'h10000 + 18'(p * 37), 2'b00, 18'h20000 + 18'(p * 53), 2'b00,
         1'b0, "R2");
    end
    for (int p = 0; p < 8; p++) begin
      op(1'b1, 1'b0, 9'(2 * p), 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R3 R4");
      op(1'b0, 1'b0, 9'd0, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R4");
    end
    drain();
  endtask

  task automatic t_order();
    op(1'b1, 1'b0, 9'd5, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R5 odd start");
    drain();
  endtask

  task automatic t_mask();
    op(1'b0, 1'b1, 9'd8, 18'h3ABCD, 2'b10, 18'h15555, 2'b01, 1'b0, "R6");
    op(1'b1, 1'b0, 9'd8, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R6 R7 lanes");
    drain();
    op(1'b0, 1'b1, 9'd10, 18'h3FFFF, 2'b11, 18'h00F0F, 2'b00, 1'b0, "R6");
    op(1'b1, 1'b0, 9'd10, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R6 R7 masked beat");
    drain();
  endtask

  task automatic t_nop();
    op(1'b0, 1'b0, 9'd12, 18'h2DEAD, 2'b00, 18'h1BEEF, 2'b00, 1'b0, "R8");
    op(1'b1, 1'b0, 9'd12, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R8 nop kept data");
    drain();
  endtask

  task automatic t_same();
    op(1'b1, 1'b1, 9'd3, 18'h0AAAA, 2'b00, 18'h05555, 2'b00, 1'b0, "R9 old data");
    op(1'b1, 1'b0, 9'd3, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R9 new data");
    drain();
  endtask

  task automatic t_b2b();
    for (int p = 0; p < 6; p++) begin
      op(1'b1, 1'b0, 9'((p * 3) % 16), 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R10");
    end
    drain();
  endtask

  task automatic t_mid();
    op(1'b0, 1'b0, 9'd14, 18'h0, 2'b11, 18'h3C3C3, 2'b00, 1'b1, "R11");
    op(1'b1, 1'b0, 9'd14, 18'h0, 2'b11, 18'h0, 2'b11, 1'b0, "R11 mid tick ignored");
    drain();
  endtask

  initial begin
    n_chk = 0; n_err = 0; cyc = 0; done = 1'b0;
    for (int i = 0; i < 512; i++) ref_mem[i] = '0;
    for (int i = 0; i < 16; i++) begin
      exp_v[i] = 1'b0; exp_d[i] = '0; exp_t[i] = "";
    end
    rst_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; addr = '0; bw_n = 2'b11; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_order();
    t_mask();
    t_nop();
    t_same();
    t_b2b();
    t_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule